// File: doc/BRIEF.md
# Serial ADC Control-Byte Front End

This block is the digital side of an 8-bit successive-approximation converter that takes its conversion clock from the host's serial clock. While chip select is low, the block watches the serial data line on rising SCLK edges. It skips any leading zeros, and the first one it sees opens an 8-bit control byte. The falling SCLK edges then pace the conversion. A track request opens two clocks before the control byte is complete. The sample is held when the byte closes. A strobe marks two clocks of waiting, and the eight result bits leave MSB first, one bit per falling edge.

The analog comparator is modelled as a digital compare between a sampled code input and the trial code of the SAR register. This keeps the complete bit-decision sequence in the design. The serial outputs are given as data/enable pairs, and the integration layer turns these into pad tri-states. SCLK, chip select and data are taken as already synchronous to the block clock. Edges are found by comparing each input with its value one clock earlier.

A new control byte may begin as soon as the MSB of the running result has left. Conversions can therefore be chained every 10 serial clocks. If chip select is toggled before the MSB appears, the next start bit abandons the running conversion.

Top module: `sadc_front_end`

## Requirements
- R1: While `cs_n` is low, `din` is sampled on each SCLK rising edge. Zeros before the first one are ignored, and that first one becomes bit 7 of the control byte. Rising edges while `cs_n` is high have no effect.
- R2: The control byte carries the following fields, with bit 7 first on the wire:
  - Bit 7 is the start bit.
  - Bits 6:4 select the channel.
  - Bit 3 selects unipolar coding (1) or bipolar coding (0).
  - Bit 2 selects single-ended operation (1).
  - Bit 1 selects the power setting.
  - Bit 0 selects serial-clocked conversion (1).

  A conversion starts only when bit 0 is 1. With bit 0 at 0, the strobe stays low and `dout_o` stays 0.
- R3: `track_o` rises on the SCLK falling edge after the 6th control bit. It falls on the falling edge after the 8th bit, and that edge captures `sample_i`.
- R4: `sstrb_o` goes high on the falling edge after the 8th control bit and stays high for exactly two SCLK periods.
- R5: The eight result bits appear on `dout_o` MSB first, on eight consecutive falling edges. The first of these is the edge on which the strobe drops. Every falling edge after the last result bit drives 0.
- R6: In unipolar mode the result equals `sample_i`, as straight binary. In bipolar mode the result is `sample_i` with its MSB inverted, as two's complement around mid-scale.
- R7: While `cs_n` is high, `dout_oe` and `sstrb_oe` are 0 and the data outputs are 0. After `cs_n` falls, the strobe is driven low.
- R8: While the strobe is high, ones on `din` are ignored. A start bit is accepted again once the MSB has been driven, so conversions can follow each other every 10 SCLK periods.
- R9: If `cs_n` rises and falls while the strobe window is open, the next one on `din` abandons the running conversion and opens a new control byte.
- R10: `ctrl_byte_o` presents the complete control byte from the falling edge after its 8th bit onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; it oversamples the serial pins |
| rst_n | input | 1 | Synchronous reset, active low |
| sclk | input | 1 | Serial clock, synchronous to `clk` |
| cs_n | input | 1 | Chip select, active low |
| din | input | 1 | Serial control data |
| sample_i | input | DATA_W | Code presented by the modelled analog input |
| dout_o | output | 1 | Serial result data |
| dout_oe | output | 1 | Drive enable for `dout_o` |
| sstrb_o | output | 1 | Conversion strobe |
| sstrb_oe | output | 1 | Drive enable for `sstrb_o` |
| track_o | output | 1 | Track request to the sample stage (1 = track, 0 = hold) |
| ctrl_byte_o | output | CTRL_W | Last complete control byte |

## Verification
The assertions take the following for granted about the inputs:
- SCLK, chip select and data each hold a level for at least two block clocks, so no two serial events land in the same clock.
- Chip select moves only while SCLK is low.
- A chip-select rise never coincides with the clock in which a new conversion is loaded.

The bench holds each SCLK half-period for four block clocks. It changes chip select only between runs of clocks with SCLK parked low. It changes `sample_i` only after the hold edge of the conversion before.

// File: rtl/sadc_pkg.sv
// Package: shared types and control-byte field positions for the
// serial ADC front end. Assumes an 8-bit control byte, start bit first.
package sadc_pkg;

    // Phase of the SAR engine after a control byte closes.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_STRB = 2'd1,
        PH_OUT  = 2'd2
    } sar_phase_e;

    // Bit positions that the engine decodes.
    localparam int CB_UNIPOLAR = 3;
    localparam int CB_EXTCLK   = 0;

endpackage

// File: rtl/sadc_ctrl_rx.sv
// Module: sadc_ctrl_rx
// Looks for the start bit and shifts in the control byte on SCLK rising
// edges. On falling edges it drives the track request. A pulse marks an
// accepted start bit, and another marks the falling edge that closes the
// byte.
// Assumes edge strobes are one clock wide and never coincide.
module sadc_ctrl_rx #(
    parameter int CTRL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              cs_low,
    input  logic              cs_fall,
    input  logic              din,
    input  logic              search_ok,
    output logic              start_o,
    output logic              done_o,
    output logic              track_o,
    output logic [CTRL_W-1:0] byte_o
);
    localparam int CNT_W    = $clog2(CTRL_W + 1);
    localparam int TRACK_AT = CTRL_W - 2;

    logic              shifting;
    logic [CNT_W-1:0]  cnt;
    logic [CTRL_W-1:0] sreg;

    // Start detection, byte shifting and track window, all on SCLK events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shifting <= 1'b0;
            cnt      <= '0;
            sreg     <= '0;
            byte_o   <= '0;
            track_o  <= 1'b0;
            start_o  <= 1'b0;
            done_o   <= 1'b0;
        end else begin
            start_o <= 1'b0;
            done_o  <= 1'b0;
            if (cs_fall) begin
                shifting <= 1'b0;
                cnt      <= '0;
                track_o  <= 1'b0;
            end else if (sclk_rise && cs_low) begin
                if (!shifting) begin
                    if (din && search_ok) begin
                        shifting <= 1'b1;
                        sreg     <= CTRL_W'(1);
                        cnt      <= CNT_W'(1);
                        start_o  <= 1'b1;
                    end
                end else if (cnt < CNT_W'(CTRL_W)) begin
                    sreg <= {sreg[CTRL_W-2:0], din};
                    cnt  <= cnt + 1'b1;
                end
            end else if (sclk_fall && shifting) begin
                if (cnt == CNT_W'(TRACK_AT)) begin
                    track_o <= 1'b1;
                end
                if (cnt == CNT_W'(CTRL_W)) begin
                    track_o  <= 1'b0;
                    shifting <= 1'b0;
                    cnt      <= '0;
                    done_o   <= 1'b1;
                    byte_o   <= sreg;
                end
            end
        end
    end

    AST_START_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> $past(cs_low)) else $error("start without cs");  // R1
    AST_TRACK_IN_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        track_o |-> shifting) else $error("track outside byte");    // R3
    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !track_o) else $error("track open at hold");     // R3

endmodule

// File: rtl/sadc_sar_core.sv
// Module: sadc_sar_core
// SAR engine paced by SCLK falling edges. It loads the held sample, opens
// the strobe for STRB_CYC edges, then decides and drives one result bit per
// edge, MSB first. After the last bit it drives zeros.
// Assumes go, abort and step never coincide.
module sadc_sar_core
    import sadc_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int STRB_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              go,
    input  logic              bipolar,
    input  logic [DATA_W-1:0] sample_i,
    input  logic              abort,
    input  logic              strobe_clr,
    output logic              dout,
    output logic              strobe,
    output logic              premsb
);
    localparam int IDX_W  = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam int SCNT_W = (STRB_CYC > 1) ? $clog2(STRB_CYC) : 1;
    localparam logic [IDX_W-1:0]  IDX_MSB   = IDX_W'(DATA_W - 1);
    localparam logic [SCNT_W-1:0] SCNT_LAST = SCNT_W'(STRB_CYC - 1);

    sar_phase_e        ph;
    logic [SCNT_W-1:0] scnt;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] acc, samp, trial;
    logic              bip, keep, bit_out, decide;

    // Trial code for the current bit and the comparator decision on it.
    always_comb begin
        trial   = acc | (DATA_W'(1) << idx);
        keep    = (samp >= trial);
        bit_out = keep ^ (bip && (idx == IDX_MSB));
        decide  = step && ((ph == PH_OUT) || ((ph == PH_STRB) && (scnt == SCNT_LAST)));
    end

    assign premsb = (ph == PH_STRB);

    // Phase sequencing, SAR register update and output bit register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph     <= PH_IDLE;
            scnt   <= '0;
            idx    <= '0;
            acc    <= '0;
            samp   <= '0;
            bip    <= 1'b0;
            dout   <= 1'b0;
            strobe <= 1'b0;
        end else if (abort) begin
            ph     <= PH_IDLE;
            dout   <= 1'b0;
            strobe <= 1'b0;
        end else if (go) begin
            ph     <= PH_STRB;
            scnt   <= '0;
            idx    <= IDX_MSB;
            acc    <= '0;
            samp   <= sample_i;
            bip    <= bipolar;
            dout   <= 1'b0;
            strobe <= 1'b1;
        end else begin
            if (strobe_clr) begin
                strobe <= 1'b0;
            end
            if (step && (ph == PH_STRB) && (scnt != SCNT_LAST)) begin
                scnt <= scnt + 1'b1;
            end
            if (decide) begin
                strobe <= 1'b0;
                dout   <= bit_out;
                if (keep) begin
                    acc <= trial;
                end
                if (idx == '0) begin
                    ph <= PH_IDLE;
                end else begin
                    ph  <= PH_OUT;
                    idx <= idx - 1'b1;
                end
            end
            if (step && (ph == PH_IDLE)) begin
                dout <= 1'b0;
            end
        end
    end

    AST_GO_OPENS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !abort) |=> (strobe && premsb)) else $error("strobe not opened");   // R4
    AST_STROBE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> (ph == PH_STRB)) else $error("strobe outside window");         // R4
    AST_IDLE_DRIVES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (step && (ph == PH_IDLE) && !go && !abort) |=> !dout) else $error("tail not zero"); // R5

endmodule

// File: rtl/sadc_front_end.sv
// Module: sadc_front_end (top)
// Finds SCLK and chip-select edges and links the control receiver to the
// SAR engine. It also applies the re-arm rule: a chip-select toggle
// during the strobe window lets a new start bit abandon the conversion.
// It drives the data/enable output pairs.
// Assumes sclk, cs_n and din are synchronous to clk.
module sadc_front_end #(
    parameter int DATA_W   = 8,
    parameter int CTRL_W   = 8,
    parameter int STRB_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              din,
    input  logic [DATA_W-1:0] sample_i,
    output logic              dout_o,
    output logic              dout_oe,
    output logic              sstrb_o,
    output logic              sstrb_oe,
    output logic              track_o,
    output logic [CTRL_W-1:0] ctrl_byte_o
);
    import sadc_pkg::*;

    logic sclk_q, cs_q, cs_toggled;
    logic sclk_rise, sclk_fall, cs_rise, cs_fall;
    logic rx_start, rx_done, conv_go, abort, search_ok;
    logic sar_dout, sar_strobe, premsb;

    // Previous pin levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            cs_q   <= 1'b1;
        end else begin
            sclk_q <= sclk;
            cs_q   <= cs_n;
        end
    end

    assign sclk_rise = sclk & ~sclk_q;
    assign sclk_fall = ~sclk & sclk_q;
    assign cs_rise   = cs_n & ~cs_q;
    assign cs_fall   = ~cs_n & cs_q;

    // Remembers a chip-select toggle seen while the strobe window is open.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_toggled <= 1'b0;
        end else if (!premsb) begin
            cs_toggled <= 1'b0;
        end else if (cs_rise) begin
            cs_toggled <= 1'b1;
        end
    end

    assign search_ok = !premsb || cs_toggled;
    assign conv_go   = rx_done && ctrl_byte_o[CB_EXTCLK];
    assign abort     = rx_start && premsb;

    sadc_ctrl_rx #(.CTRL_W(CTRL_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_low    (~cs_n),
        .cs_fall   (cs_fall),
        .din       (din),
        .search_ok (search_ok),
        .start_o   (rx_start),
        .done_o    (rx_done),
        .track_o   (track_o),
        .byte_o    (ctrl_byte_o)
    );

    sadc_sar_core #(.DATA_W(DATA_W), .STRB_CYC(STRB_CYC)) u_sar (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (sclk_fall),
        .go         (conv_go),
        .bipolar    (~ctrl_byte_o[CB_UNIPOLAR]),
        .sample_i   (sample_i),
        .abort      (abort),
        .strobe_clr (cs_rise),
        .dout       (sar_dout),
        .strobe     (sar_strobe),
        .premsb     (premsb)
    );

    assign dout_oe  = ~cs_n;
    assign sstrb_oe = ~cs_n;
    assign dout_o   = sar_dout & ~cs_n;
    assign sstrb_o  = sar_strobe & ~cs_n;

    AST_GO_OUTSIDE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        conv_go |-> !premsb) else $error("load during strobe window");      // R8
    AST_ABORT_NEEDS_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> cs_toggled) else $error("abort without cs toggle");       // R9
    AST_CS_RISE_DROPS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && !conv_go) |=> !sar_strobe) else $error("strobe kept");  // R7

endmodule

// File: tb/sadc_front_end_bench.sv
// Bench: drives SCLK at eight block clocks per period and runs a full sweep
// of back-to-back conversions over every code in both codings. It then
// runs directed cases for leading zeros, ignored clocks, mode bit 0, the
// strobe window and abort.
module sadc_front_end_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b0;
    logic       cs_n = 1'b1;
    logic       din = 1'b0;
    logic [7:0] sample_i = '0;
    logic       dout_o, dout_oe, sstrb_o, sstrb_oe, track_o;
    logic [7:0] ctrl_byte_o;

    int checks = 0;
    int fails  = 0;
    logic d_log [64];
    logic s_log [64];
    logic t_log [64];

    always #(CLK_PERIOD / 2) clk = ~clk;

    sadc_front_end u_sadc_front_end (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din),
        .sample_i(sample_i), .dout_o(dout_o), .dout_oe(dout_oe),
        .sstrb_o(sstrb_o), .sstrb_oe(sstrb_oe), .track_o(track_o),
        .ctrl_byte_o(ctrl_byte_o)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One SCLK period per bit; outputs are logged just before each rising edge.
    task automatic run_bits(input logic [63:0] v, input int n);
        for (int i = 0; i < n; i++) begin
            din = v[n-1-i];
            repeat (HALF) @(negedge clk);
            d_log[i] = dout_o;
            s_log[i] = sstrb_o;
            t_log[i] = track_o;
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cs_toggle();
        cs_n = 1'b1;
        wait_clks(2 * HALF);
        cs_n = 1'b0;
        wait_clks(2 * HALF);
    endtask

    // Checks the track, strobe and data windows of a conversion whose start bit is at index s.
    task automatic check_conv(input int s, input int n, input logic [7:0] exp, input string req);
        logic [63:0] at, et, as, es, ad, ed;
        at = '0; et = '0; as = '0; es = '0; ad = '0; ed = '0;
        for (int t = s; t < n; t++) begin
            at[t] = t_log[t];
            et[t] = (t == s + 6) || (t == s + 7);
            as[t] = s_log[t];
            es[t] = (t == s + 8) || (t == s + 9);
            ad[t] = d_log[t];
            if (t >= s + 10 && t <= s + 17) ed[t] = exp[17 + s - t];
        end
        check(at == et, {req, " R3 track window"}, at, et);
        check(as == es, {req, " R4 strobe window"}, as, es);
        check(ad == ed, {req, " R5 result bits"}, ad, ed);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [7:0] prev_exp;
        logic [7:0] got;
        logic [9:0] sv, tv;
        logic [7:0] c;

        wait_clks(5);
        rst_n = 1'b1;
        wait_clks(2);
        // R7: reset state with chip select high.
        check(!dout_oe && !sstrb_oe && !dout_o && !sstrb_o, "R7 reset outputs",
              {dout_oe, sstrb_oe, dout_o, sstrb_o}, 64'h0);
        check(!track_o && ctrl_byte_o == 8'h00, "R3 R10 reset track/byte",
              {track_o, ctrl_byte_o}, 64'h0);

        // R1: rising edges with chip select high are ignored.
        run_bits(64'hFFF, 12);
        check(!dout_oe && !sstrb_oe, "R7 enables off while cs high", {dout_oe, sstrb_oe}, 64'h0);
        cs_n = 1'b0;
        wait_clks(2 * HALF);
        check(dout_oe && sstrb_oe && !sstrb_o, "R7 strobe driven low after cs fall",
              {dout_oe, sstrb_oe, sstrb_o}, 64'h6);
        run_bits(64'h0, 12);
        got = '0;
        for (int i = 0; i < 12; i++) got[0] = got[0] | s_log[i] | d_log[i];
        check(got[0] == 1'b0, "R1 no conversion from clocks with cs high", got, 64'h0);

        // R6 R8: back-to-back 10-clock conversions over every code, both codings.
        prev_exp = '0;
        for (int n = 0; n < 513; n++) begin
            logic uni;
            uni = (n < 256);
            if (n < 512) begin
                c = {1'b1, 3'(n % 8), uni, 3'b111};
                sample_i = 8'(n % 256);
            end else begin
                c = 8'h00;
            end
            run_bits({54'b0, c, 2'b00}, 10);
            for (int i = 0; i < 10; i++) begin
                sv[i] = s_log[9-i];
                tv[i] = t_log[9-i];
            end
            if (n > 0) begin
                for (int i = 0; i < 8; i++) got[7-i] = d_log[i];
                check(got == prev_exp, "R6 R8 streamed result", got, prev_exp);
            end
            if (n < 512) begin
                check(sv == 10'b0000000011, "R4 strobe in sweep", sv, 10'b0000000011);
                check(tv == 10'b0000001100, "R3 track in sweep", tv, 10'b0000001100);
                check(ctrl_byte_o == c, "R10 control byte in sweep", ctrl_byte_o, c);
                prev_exp = uni ? 8'(n % 256) : (8'(n % 256) ^ 8'h80);
            end
        end

        // R1 R5: leading zeros, then a unipolar conversion, then trailing zeros.
        cs_toggle();
        sample_i = 8'hA5;
        c = 8'b1_010_1_1_1_1;
        run_bits(64'(c) << 12, 25);
        check_conv(5, 25, 8'hA5, "R1 leading zeros");

        // R2: mode bit 0 clear launches no conversion.
        cs_toggle();
        sample_i = 8'h77;
        c = 8'b1_000_1_1_1_0;
        run_bits(64'(c) << 12, 20);
        got = '0;
        for (int i = 0; i < 20; i++) got[0] = got[0] | s_log[i] | d_log[i];
        check(got[0] == 1'b0, "R2 no conversion with bit 0 clear", got, 64'h0);
        check(ctrl_byte_o == c, "R10 byte latched with bit 0 clear", ctrl_byte_o, c);

        // R8: ones inside the strobe window are not start bits.
        cs_toggle();
        sample_i = 8'h5A;
        c = 8'b1_011_1_1_0_1;
        run_bits((64'(c) << 14) | (64'h3 << 12), 22);
        check_conv(0, 22, 8'h5A, "R8 ones ignored in strobe window");

        // R9: cs toggle in the strobe window, then a new start bit, abandons the conversion.
        cs_toggle();
        sample_i = 8'h3C;
        c = 8'b1_000_1_1_1_1;
        run_bits(64'(c) << 1, 9);
        check(s_log[8] == 1'b1, "R4 strobe open before toggle", s_log[8], 64'h1);
        cs_n = 1'b1;
        wait_clks(2 * HALF);
        check(!sstrb_oe && !dout_oe, "R7 enables off on toggle", {sstrb_oe, dout_oe}, 64'h0);
        cs_n = 1'b0;
        wait_clks(2 * HALF);
        check(!sstrb_o, "R7 strobe low after cs fall", sstrb_o, 64'h0);
        sample_i = 8'hC3;
        c = 8'b1_001_1_1_1_1;
        run_bits(64'(c) << 12, 20);
        check_conv(0, 20, 8'hC3, "R9 abort and restart");
        check(ctrl_byte_o == c, "R9 R10 new byte after abort", ctrl_byte_o, c);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule